// File: doc/BRIEF.md
# Host-Side Byte Mailbox with Status Flags

This block sits between an 8-bit master processor bus and a local controller. The master writes bytes into an input holding register and reads bytes from an output holding register. It also reads a status byte that combines four software-defined bits with handshake flags. Each master write records whether it came in as data or as a command. The local side loads the output register, takes bytes from the input register, and sets the software-defined status bits. It sees the whole status byte at all times.

The master strobes are sampled by the block clock and act on their trailing (rising) edge. When the master reads the status byte, local updates to the status bits are held back until that read ends. Four upper port pins work as plain latched outputs after reset. A local pulse turns two of them into buffer-flag interrupt pins. Another local pulse turns the other two into a DMA request output and a DMA acknowledge input, and that acknowledge selects the data registers.

Top module: `host_if_buffer`

## Requirements
- R1: The active-low reset input passes through a two-stage synchronizer. After reset the status byte is 0x00, the input register is 0x00, port_pins is 4'b1111, and both pin modes are off.
- R2: A selected master write is one where cs_n (or the DMA acknowledge) is low while wr_n is sampled low. On its trailing edge it stores the byte present at the last clock edge that sampled wr_n low, and it sets IBF. It sets F1 to A0 (1 = command, 0 = data). These effects appear at the clock edge after the first edge that samples wr_n high.
- R3: A local read pulse (ibuf_rd) clears IBF at the next edge. If a write edge takes effect at the same edge, IBF is set instead.
- R4: A master strobe with cs_n high and no active DMA acknowledge changes no register and leaves bus_oe low.
- R5: A selected read with A0=0 drives the output register onto bus_out and clears OBF one edge after the trailing edge is first sampled. A local load (obuf_ld) stores obuf_data and sets OBF, and it wins over a clear at the same edge.
- R6: A selected read with A0=1 drives the status byte {ST7,ST6,ST5,ST4,F1,F0,IBF,OBF}, with bit 7 first, and changes no flag.
- R7: sts_ld copies sts_src into status bits 7–4, and f0_ld copies f0_val into bit 2. Bits 3, 1 and 0 do not change.
- R8: The lock is active while the master is reading the status byte, as seen by the sampled cs_n, A0 and rd_n. During the lock, sts_ld and f0_ld are held pending and are applied at the first edge after the lock ends. A newer load replaces the pending one.
- R9: bus_oe is high exactly when rd_n is low and either cs_n is low or the DMA mode is on with dack_n low.
- R10: In flags mode, port_pins[0] shows OBF when port latch bit 0 is 1, and port_pins[1] shows the inverse of IBF when latch bit 1 is 1. Each pin is low when its latch bit is 0. Outside flags mode the pins follow the latch.
- R11: In DMA mode, port_wr with port_src[2]=1 raises DRQ on port_pins[2]. DRQ clears after a DMA-acknowledged read or write edge, or on dma_en.
- R12: In DMA mode, dack_n low selects the data registers whatever the value of A0 (reads return the output register, and writes set F1=0). port_pins[3] is released high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized inside |
| cs_n | input | 1 | Master chip select, active low |
| a0 | input | 1 | Master address: 0 data, 1 command/status |
| rd_n | input | 1 | Master read strobe, active low |
| wr_n | input | 1 | Master write strobe, active low |
| bus_in | input | 8 | Master write data |
| bus_out | output | 8 | Master read data |
| bus_oe | output | 1 | Drive enable for bus_out |
| dack_n | input | 1 | DMA acknowledge, active low, used in DMA mode |
| obuf_ld | input | 1 | Local pulse: load output register |
| obuf_data | input | 8 | Byte for the output register |
| ibuf_rd | input | 1 | Local pulse: input register taken |
| ibuf_data | output | 8 | Input register contents |
| sts_ld | input | 1 | Local pulse: load status bits 7–4 |
| sts_src | input | 4 | Value for status bits 7–4 |
| f0_ld | input | 1 | Local pulse: load F0 |
| f0_val | input | 1 | Value for F0 |
| port_wr | input | 1 | Local pulse: write the port latch |
| port_src | input | 4 | Port latch value for pins 7–4 |
| flags_en | input | 1 | Local pulse: switch pins 4/5 to flag mode |
| dma_en | input | 1 | Local pulse: switch pins 6/7 to DMA mode and clear DRQ |
| port_pins | output | 4 | Upper port pins, index 0 is pin 4 |
| local_status | output | 8 | Status byte as seen by the local side |

## Verification
The assertions take for granted that the master holds cs_n, a0 and bus_in steady for at least one clock edge on each side of a strobe edge. They also assume rd_n and wr_n are never low together, and that the strobes change no faster than the clock can sample them. The stimulus drives every input 2 ns after a rising edge. It keeps each strobe low for three edges, holds the select for one edge past the trailing edge, and then inserts idle cycles before the next access.

// File: rtl/host_if_buffer.sv
module host_if_buffer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       a0,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  input  logic       dack_n,
  input  logic       obuf_ld,
  input  logic [7:0] obuf_data,
  input  logic       ibuf_rd,
  output logic [7:0] ibuf_data,
  input  logic       sts_ld,
  input  logic [3:0] sts_src,
  input  logic       f0_ld,
  input  logic       f0_val,
  input  logic       port_wr,
  input  logic [3:0] port_src,
  input  logic       flags_en,
  input  logic       dma_en,
  output logic [3:0] port_pins,
  output logic [7:0] local_status
);

  logic rs1, rs2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs1 <= 1'b0;
      rs2 <= 1'b0;
    end else begin
      rs1 <= 1'b1;
      rs2 <= rs1;
    end

  logic       rd_q, rd_qq, wr_q, wr_qq, cs_q, a0_q, dk_q;
  logic [7:0] din_q, acc_byte, ibuf, obuf;
  logic       acc_sel, acc_a0, acc_dk;
  logic       ibf, obf, f1, f0, f0_pend, f0_pval, hi_pend;
  logic       flags_mode, dma_mode, drq;
  logic [3:0] st_hi, hi_pval, plat;

  logic dk_sel_q, rd_edge, wr_edge, wr_hit, rd_data_hit, dk_done, lock, dk_sel;
  assign dk_sel_q    = dma_mode & ~dk_q;
  assign rd_edge     = rd_q & ~rd_qq;
  assign wr_edge     = wr_q & ~wr_qq;
  assign wr_hit      = wr_edge & acc_sel;
  assign rd_data_hit = rd_edge & acc_sel & ~acc_a0;
  assign dk_done     = (rd_edge | wr_edge) & acc_dk;
  assign lock        = ~rd_q & ~cs_q & a0_q & ~dk_sel_q;

  always_ff @(posedge clk)
    if (!rs2) begin
      rd_q <= 1'b1; rd_qq <= 1'b1; wr_q <= 1'b1; wr_qq <= 1'b1;
      cs_q <= 1'b1; a0_q <= 1'b0; dk_q <= 1'b1; din_q <= '0;
      acc_sel <= 1'b0; acc_a0 <= 1'b0; acc_dk <= 1'b0; acc_byte <= '0;
    end else begin
      rd_q <= rd_n; rd_qq <= rd_q; wr_q <= wr_n; wr_qq <= wr_q;
      cs_q <= cs_n; a0_q <= a0; dk_q <= dack_n; din_q <= bus_in;
      if (!rd_q || !wr_q) begin
        acc_sel  <= ~cs_q | dk_sel_q;
        acc_a0   <= a0_q & ~dk_sel_q;
        acc_dk   <= dk_sel_q;
        acc_byte <= din_q;
      end
    end

  always_ff @(posedge clk)
    if (!rs2) begin
      ibuf <= '0; obuf <= '0; ibf <= 1'b0; obf <= 1'b0; f1 <= 1'b0;
    end else begin
      if (wr_hit) begin
        ibuf <= acc_byte;
        f1   <= acc_a0;
      end
      if (wr_hit) ibf <= 1'b1;
      else if (ibuf_rd) ibf <= 1'b0;
      if (obuf_ld) begin
        obuf <= obuf_data;
        obf  <= 1'b1;
      end else if (rd_data_hit) obf <= 1'b0;
    end

  always_ff @(posedge clk)
    if (!rs2) begin
      st_hi <= '0; hi_pend <= 1'b0; hi_pval <= '0;
      f0 <= 1'b0; f0_pend <= 1'b0; f0_pval <= 1'b0;
    end else if (lock) begin
      if (sts_ld) begin
        hi_pend <= 1'b1;
        hi_pval <= sts_src;
      end
      if (f0_ld) begin
        f0_pend <= 1'b1;
        f0_pval <= f0_val;
      end
    end else begin
      hi_pend <= 1'b0;
      f0_pend <= 1'b0;
      if (sts_ld) st_hi <= sts_src;
      else if (hi_pend) st_hi <= hi_pval;
      if (f0_ld) f0 <= f0_val;
      else if (f0_pend) f0 <= f0_pval;
    end

  always_ff @(posedge clk)
    if (!rs2) begin
      plat <= 4'hF; flags_mode <= 1'b0; dma_mode <= 1'b0; drq <= 1'b0;
    end else begin
      if (port_wr) plat <= port_src;
      if (flags_en) flags_mode <= 1'b1;
      if (dma_en) dma_mode <= 1'b1;
      if (dma_en || dk_done) drq <= 1'b0;
      else if (dma_mode && port_wr && port_src[2]) drq <= 1'b1;
    end

  assign local_status = {st_hi, f1, f0, ibf, obf};
  assign ibuf_data    = ibuf;
  assign dk_sel       = dma_mode & ~dack_n;
  assign bus_oe       = (~cs_n | dk_sel) & ~rd_n;
  assign bus_out      = (a0 & ~dk_sel) ? local_status : obuf;
  assign port_pins    = {dma_mode | plat[3],
                         dma_mode ? drq : plat[2],
                         plat[1] & ~(flags_mode & ibf),
                         plat[0] & (~flags_mode | obf)};

  // R2
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rs2) wr_hit |=> ibf);
  // R5
  obf_clr_chk: assert property (@(posedge clk) disable iff (!rs2)
    (rd_data_hit && !obuf_ld) |=> !obf);
  // R6
  sts_read_chk: assert property (@(posedge clk) disable iff (!rs2)
    (rd_edge && acc_sel && acc_a0 && !obuf_ld) |=> $stable(obf));
  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rs2)
    lock |=> ($stable(st_hi) && $stable(f0)));
  // R9
  oe_sel_chk: assert property (@(posedge clk) disable iff (!rs2)
    bus_oe |-> (!rd_n && (!cs_n || !dack_n)));
  // R11
  drq_clr_chk: assert property (@(posedge clk) disable iff (!rs2)
    (dma_en || dk_done) |=> !drq);
  // R10
  pin_off_chk: assert property (@(posedge clk) disable iff (!rs2)
    (flags_mode && !plat[0]) |-> !port_pins[0]);

endmodule

// File: tb/host_if_buffer_tb.sv
module host_if_buffer_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, a0 = 1'b0, rd_n = 1'b1, wr_n = 1'b1, dack_n = 1'b1;
  logic [7:0] bus_in = '0, obuf_data = '0;
  logic obuf_ld = 0, ibuf_rd = 0, sts_ld = 0, f0_ld = 0, f0_val = 0, port_wr = 0;
  logic flags_en = 0, dma_en = 0;
  logic [3:0] sts_src = '0, port_src = '0;
  logic [7:0] bus_out, ibuf_data, local_status;
  logic bus_oe;
  logic [3:0] port_pins;

  host_if_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .a0(a0), .rd_n(rd_n), .wr_n(wr_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .dack_n(dack_n),
    .obuf_ld(obuf_ld), .obuf_data(obuf_data), .ibuf_rd(ibuf_rd), .ibuf_data(ibuf_data),
    .sts_ld(sts_ld), .sts_src(sts_src), .f0_ld(f0_ld), .f0_val(f0_val),
    .port_wr(port_wr), .port_src(port_src), .flags_en(flags_en), .dma_en(dma_en),
    .port_pins(port_pins), .local_status(local_status));

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit cmp_on = 0, done = 0;

  // behavioural reference
  bit ms1, ms2;
  bit [7:0] m_ibuf, m_obuf;
  bit m_ibf, m_obf, m_f1, m_f0, m_fl, m_dm, m_drq;
  bit [3:0] m_hi, m_lat;
  bit ph, pf, pfv;
  bit [3:0] phv;
  bit pv_rd, pv_wr, pv_cs, pv_a0, pv_dk;
  bit [7:0] pv_din;
  bit ev_w, ev_r, ev_sel, ev_a0, ev_dk;
  bit [7:0] ev_d;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin ms1 <= 0; ms2 <= 0; end
    else begin ms1 <= 1; ms2 <= ms1; end

  always @(posedge clk) begin
    if (!ms2) begin
      m_ibuf = 0; m_obuf = 0; m_ibf = 0; m_obf = 0; m_f1 = 0; m_f0 = 0;
      m_fl = 0; m_dm = 0; m_drq = 0; m_hi = 0; m_lat = 4'hF;
      ph = 0; pf = 0; pfv = 0; phv = 0;
      pv_rd = 1; pv_wr = 1; pv_cs = 1; pv_a0 = 0; pv_dk = 1; pv_din = 0;
      ev_w = 0; ev_r = 0; ev_sel = 0; ev_a0 = 0; ev_dk = 0; ev_d = 0;
    end else begin
      automatic bit dm_old = m_dm;
      automatic bit lk = !pv_rd && !pv_cs && pv_a0 && !(dm_old && !pv_dk);
      automatic bit dkp = dm_old && !pv_dk;
      if (ev_w && ev_sel) begin m_ibuf = ev_d; m_f1 = ev_a0; m_ibf = 1; end
      else if (ibuf_rd) m_ibf = 0;
      if (obuf_ld) begin m_obuf = obuf_data; m_obf = 1; end
      else if (ev_r && ev_sel && !ev_a0) m_obf = 0;
      if (lk) begin
        if (sts_ld) begin ph = 1; phv = sts_src; end
        if (f0_ld) begin pf = 1; pfv = f0_val; end
      end else begin
        if (sts_ld) m_hi = sts_src; else if (ph) m_hi = phv;
        if (f0_ld) m_f0 = f0_val; else if (pf) m_f0 = pfv;
        ph = 0; pf = 0;
      end
      if (dma_en || ((ev_w || ev_r) && ev_dk)) m_drq = 0;
      else if (dm_old && port_wr && port_src[2]) m_drq = 1;
      if (port_wr) m_lat = port_src;
      if (flags_en) m_fl = 1;
      if (dma_en) m_dm = 1;
      ev_w = !pv_wr && wr_n; ev_r = !pv_rd && rd_n;
      ev_dk = dkp; ev_sel = !pv_cs || dkp; ev_a0 = pv_a0 && !dkp; ev_d = pv_din;
      pv_rd = rd_n; pv_wr = wr_n; pv_cs = cs_n; pv_a0 = a0; pv_dk = dack_n; pv_din = bus_in;
    end
  end

  task automatic cmp(string what, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    automatic bit [7:0] st = {m_hi, m_f1, m_f0, m_ibf, m_obf};
    automatic bit dsel = m_dm && !dack_n;
    automatic bit oe = (!cs_n || dsel) && !rd_n;
    automatic bit [3:0] pins = {m_dm | m_lat[3], m_dm ? m_drq : m_lat[2],
                                m_lat[1] & ~(m_fl & m_ibf), m_lat[0] & (~m_fl | m_obf)};
    cmp("local_status", local_status, st);
    cmp("ibuf_data", ibuf_data, m_ibuf);
    cmp("port_pins", {4'h0, port_pins}, {4'h0, pins});
    cmp("bus_oe", {7'h0, bus_oe}, {7'h0, oe});
    if (oe) cmp("bus_out", bus_out, (a0 && !dsel) ? st : m_obuf);
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic idle(int n); repeat (n) tick(); endtask

  task automatic mwrite(bit sel_cs, bit sel_dk, bit av, bit [7:0] d);
    tick(); cs_n = !sel_cs; dack_n = !sel_dk; a0 = av; bus_in = d; wr_n = 0;
    idle(3); wr_n = 1;
    tick(); cs_n = 1; dack_n = 1; bus_in = 0;
    idle(3);
  endtask

  task automatic mread(bit sel_cs, bit sel_dk, bit av);
    tick(); cs_n = !sel_cs; dack_n = !sel_dk; a0 = av; rd_n = 0;
    idle(3); rd_n = 1;
    tick(); cs_n = 1; dack_n = 1;
    idle(3);
  endtask

  task automatic pulse_obuf(bit [7:0] d); tick(); obuf_ld = 1; obuf_data = d; tick(); obuf_ld = 0; idle(2); endtask
  task automatic pulse_port(bit [3:0] v); tick(); port_wr = 1; port_src = v; tick(); port_wr = 0; idle(2); endtask
  task automatic pulse_sts(bit [3:0] v, bit f); tick(); sts_ld = 1; sts_src = v; f0_ld = 1; f0_val = f; tick(); sts_ld = 0; f0_ld = 0; idle(2); endtask

  initial begin
    idle(2); cmp_on = 1; idle(2);
    rst_n = 1; idle(4);
    cur_req = "R2"; mwrite(1, 0, 0, 8'h5A); mwrite(1, 0, 1, 8'hC3);
    cur_req = "R3"; tick(); ibuf_rd = 1; tick(); ibuf_rd = 0; idle(2);
    cur_req = "R4"; mwrite(0, 0, 0, 8'h99); pulse_obuf(8'h3C); mread(0, 0, 0);
    cur_req = "R5"; mread(1, 0, 0); pulse_obuf(8'h81);
    cur_req = "R6"; mread(1, 0, 1); mwrite(1, 0, 0, 8'h11); mread(1, 0, 1);
    cur_req = "R7"; pulse_sts(4'hA, 1); pulse_sts(4'h3, 0);
    cur_req = "R8";
    tick(); cs_n = 0; a0 = 1; rd_n = 0; idle(2);
    sts_ld = 1; sts_src = 4'h5; f0_ld = 1; f0_val = 1; tick();
    sts_ld = 1; sts_src = 4'h6; f0_ld = 0; tick(); sts_ld = 0; idle(2);
    rd_n = 1; tick(); cs_n = 1; idle(4);
    cur_req = "R9"; mread(1, 0, 0); tick(); rd_n = 0; dack_n = 0; idle(2); rd_n = 1; dack_n = 1; idle(2);
    cur_req = "R10"; tick(); flags_en = 1; tick(); flags_en = 0; idle(2);
    pulse_port(4'b0011); pulse_obuf(8'h42); mread(1, 0, 0); mwrite(1, 0, 0, 8'h77);
    tick(); ibuf_rd = 1; tick(); ibuf_rd = 0; idle(2); pulse_port(4'b0000); pulse_obuf(8'h43);
    cur_req = "R11"; pulse_port(4'b0100); tick(); dma_en = 1; tick(); dma_en = 0; idle(2);
    pulse_port(4'b0100); mread(0, 1, 0);
    pulse_port(4'b0100); mwrite(0, 1, 0, 8'h2D);
    pulse_port(4'b0100); tick(); dma_en = 1; tick(); dma_en = 0; idle(2);
    cur_req = "R12"; pulse_obuf(8'hE7); mread(0, 1, 1); mwrite(0, 1, 1, 8'hB4); mread(1, 0, 1);
    idle(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog %s: got timeout expected completion", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule